// File: doc/BRIEF.md
# Shift-Step Multiply/Divide Unit

This block is a sequential unsigned arithmetic engine built around three operand registers, X, Y and Z. Each register is W = 8*N bits wide, where N (1 to 4) is a parameter. A multiply forms Y + X*Z and leaves the double-width result split across Y (upper half) and Z (lower half). A divide treats Y:Z as a double-width dividend and X as the divisor. It leaves the quotient in Z and the remainder in Y. X is never altered by an operation.

Software loads the operands through a simple register write port, then writes a control byte that selects the operation and can zero Y and/or Z. The block advances one step on every cycle in which the external `shift_en` pulse is high. An operation takes exactly W+1 such pulses: W arithmetic steps (add and shift right for multiply, compare, subtract and shift left for divide) followed by one closing step. The status byte holds a divide overflow flag, which is set when the divisor is not larger than the upper half of the dividend.

Top module: `shiftmd_unit`

## Requirements
- R1: After reset, X, Y and Z read zero, the status byte reads zero, and busy and done are low.
- R2: A multiply command (control bits [1:0] = 01) leaves Y:Z equal to the Y value plus X times Z, as those values stand after the command's clears. The upper W bits go to Y and the lower W bits to Z. X is unchanged.
- R3: A divide command (control bits [1:0] = 10) with X greater than Y leaves Z equal to the quotient of Y:Z by X and Y equal to the remainder. X is unchanged.
- R4: Every accepted control write sets status bit 0 to 1 exactly when the command is a divide and X is less than or equal to the Y value after the clears; division by zero therefore sets it. Any other command clears the bit. Status bits 7:1 always read 0.
- R5: Control bit 2 zeroes Z and control bit 3 zeroes Y in the same cycle the control byte is accepted, before any arithmetic.
- R6: Control codes 00 and 11 start nothing. Busy stays low and Y and Z change only through the clear bits.
- R7: Busy rises one cycle after a multiply or divide command. It stays high until the (W+1)-th shift pulse after the command. In that same cycle busy falls and done is high for exactly one cycle.
- R8: Writes to X, Y, Z or the control byte are ignored while busy is high.
- R9: While busy, Y and Z hold their values in every cycle without a shift pulse, and busy does not end without the full pulse count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shift_en | input | 1 | Step pulse; one operation step per high cycle |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 00 X, 01 Z, 10 Y, 11 control byte |
| wr_data | input | W | Write data; control byte in bits [7:0] |
| x_out | output | W | Current X register |
| y_out | output | W | Current Y register |
| z_out | output | W | Current Z register |
| status_out | output | 8 | Status byte, overflow in bit 0 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse at operation end |

## Verification
The hardest state to reach is an operation that has started but is stalled between shift pulses while software keeps writing. The ports only show the start and the end of an operation, so a mistake in gating would stay hidden if the pulses ran back to back. The stimulus therefore starts a multiply, holds `shift_en` low for many cycles, and fires writes to every register and a clearing control byte into that window. It then checks that the result and X come out unaffected. The vector loop also spaces pulses with zero, one or two idle cycles, so that step counting is tested against an irregular pulse train.

// File: rtl/shiftmd_pkg.sv
package shiftmd_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'b00,
    OP_MUL  = 2'b01,
    OP_DIV  = 2'b10,
    OP_BAD  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SEL_X   = 2'b00,
    SEL_Z   = 2'b01,
    SEL_Y   = 2'b10,
    SEL_CTL = 2'b11
  } sel_e;

  localparam int unsigned CTL_BIT_CLR_Z = 2;
  localparam int unsigned CTL_BIT_CLR_Y = 3;
endpackage

// File: rtl/shiftmd_decode.sv
module shiftmd_decode
  import shiftmd_pkg::*;
(
  input  logic       wr_en,
  input  logic [1:0] wr_sel,
  input  logic [3:0] ctl_bits,
  input  logic       busy,
  output logic       ld_x,
  output logic       ld_y,
  output logic       ld_z,
  output logic       ctl_wr,
  output logic       clr_y,
  output logic       clr_z,
  output op_e        cmd_op,
  output logic       start
);
  logic accept;
  sel_e sel;

  assign sel    = sel_e'(wr_sel);
  assign accept = wr_en && !busy;
  assign ld_x   = accept && (sel == SEL_X);
  assign ld_y   = accept && (sel == SEL_Y);
  assign ld_z   = accept && (sel == SEL_Z);
  assign ctl_wr = accept && (sel == SEL_CTL);
  assign cmd_op = op_e'(ctl_bits[1:0]);
  assign clr_z  = ctl_wr && ctl_bits[CTL_BIT_CLR_Z];
  assign clr_y  = ctl_wr && ctl_bits[CTL_BIT_CLR_Y];
  assign start  = ctl_wr && ((cmd_op == OP_MUL) || (cmd_op == OP_DIV));
endmodule

// File: rtl/shiftmd_seq.sv
module shiftmd_seq
  import shiftmd_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  op_e  start_op,
  input  logic shift_en,
  output logic busy,
  output logic done,
  output logic step_en,
  output logic last_step,
  output op_e  op_q
);
  localparam int unsigned STEPS = W + 1;
  localparam int unsigned CW    = $clog2(STEPS + 1);

  logic [CW-1:0] cnt;

  assign last_step = busy && shift_en && (cnt == CW'(STEPS - 1));
  assign step_en   = busy && shift_en && (cnt < CW'(W));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      done <= 1'b0;
      cnt  <= '0;
      op_q <= OP_NONE;
    end else begin
      done <= 1'b0;
      if (start) begin
        busy <= 1'b1;
        cnt  <= '0;
        op_q <= start_op;
      end else if (busy && shift_en) begin
        cnt <= cnt + 1'b1;
        if (last_step) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/shiftmd_regs.sv
module shiftmd_regs
  import shiftmd_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] wr_data,
  input  logic         ld_x,
  input  logic         ld_y,
  input  logic         ld_z,
  input  logic         clr_y,
  input  logic         clr_z,
  input  logic         step_en,
  input  op_e          op,
  output logic [W-1:0] x_q,
  output logic [W-1:0] y_q,
  output logic [W-1:0] z_q
);
  // One add-and-shift-right step: returns {new Y, new Z}.
  function automatic logic [2*W-1:0] mul_step(input logic [W-1:0] xv,
                                               input logic [W-1:0] yv,
                                               input logic [W-1:0] zv);
    logic [W:0] acc;
    acc = {1'b0, yv} + (zv[0] ? {1'b0, xv} : {(W+1){1'b0}});
    return {acc, zv[W-1:1]};
  endfunction

  // One restoring compare/subtract-and-shift-left step: returns {new Y, new Z}.
  function automatic logic [2*W-1:0] div_step(input logic [W-1:0] xv,
                                               input logic [W-1:0] yv,
                                               input logic [W-1:0] zv);
    logic [W:0] part;
    logic [W:0] diff;
    logic       qbit;
    part = {yv, zv[W-1]};
    qbit = (part >= {1'b0, xv});
    diff = qbit ? (part - {1'b0, xv}) : part;
    return {diff[W-1:0], zv[W-2:0], qbit};
  endfunction

  logic [W-1:0] y_n, z_n;

  always_comb begin
    y_n = y_q;
    z_n = z_q;
    if (step_en) begin
      case (op)
        OP_MUL:  {y_n, z_n} = mul_step(x_q, y_q, z_q);
        OP_DIV:  {y_n, z_n} = div_step(x_q, y_q, z_q);
        default: ;
      endcase
    end
    if (clr_y) y_n = '0;
    if (clr_z) z_n = '0;
    if (ld_y)  y_n = wr_data;
    if (ld_z)  z_n = wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      x_q <= '0;
      y_q <= '0;
      z_q <= '0;
    end else begin
      if (ld_x) x_q <= wr_data;
      y_q <= y_n;
      z_q <= z_n;
    end
  end
endmodule

// File: rtl/shiftmd_flag.sv
module shiftmd_flag
  import shiftmd_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctl_wr,
  input  op_e          cmd_op,
  input  logic         clr_y,
  input  logic [W-1:0] x_q,
  input  logic [W-1:0] y_q,
  output logic [7:0]   status
);
  logic [W-1:0] y_eff;
  logic         ov_q;

  assign y_eff  = clr_y ? '0 : y_q;
  assign status = {7'd0, ov_q};

  always_ff @(posedge clk) begin
    if (!rst_n)      ov_q <= 1'b0;
    else if (ctl_wr) ov_q <= (cmd_op == OP_DIV) && (x_q <= y_eff);
  end
endmodule

// File: rtl/shiftmd_unit.sv
module shiftmd_unit
  import shiftmd_pkg::*;
#(
  parameter int unsigned N = 4,
  localparam int unsigned W = 8 * N
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_en,
  input  logic         wr_en,
  input  logic [1:0]   wr_sel,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out,
  output logic [W-1:0] z_out,
  output logic [7:0]   status_out,
  output logic         busy,
  output logic         done
);
  logic ld_x, ld_y, ld_z, ctl_wr, clr_y, clr_z;
  logic start_evt, step_evt, final_evt;
  op_e  cmd_op, run_op;

  shiftmd_decode u_dec (
    .wr_en    (wr_en),
    .wr_sel   (wr_sel),
    .ctl_bits (wr_data[3:0]),
    .busy     (busy),
    .ld_x     (ld_x),
    .ld_y     (ld_y),
    .ld_z     (ld_z),
    .ctl_wr   (ctl_wr),
    .clr_y    (clr_y),
    .clr_z    (clr_z),
    .cmd_op   (cmd_op),
    .start    (start_evt)
  );

  shiftmd_seq #(.W(W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_evt),
    .start_op  (cmd_op),
    .shift_en  (shift_en),
    .busy      (busy),
    .done      (done),
    .step_en   (step_evt),
    .last_step (final_evt),
    .op_q      (run_op)
  );

  shiftmd_regs #(.W(W)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_data (wr_data),
    .ld_x    (ld_x),
    .ld_y    (ld_y),
    .ld_z    (ld_z),
    .clr_y   (clr_y),
    .clr_z   (clr_z),
    .step_en (step_evt),
    .op      (run_op),
    .x_q     (x_out),
    .y_q     (y_out),
    .z_q     (z_out)
  );

  shiftmd_flag #(.W(W)) u_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .ctl_wr (ctl_wr),
    .cmd_op (cmd_op),
    .clr_y  (clr_y),
    .x_q    (x_out),
    .y_q    (y_out),
    .status (status_out)
  );
endmodule

// File: rtl/shiftmd_checker.sv
module shiftmd_checker #(
  parameter int unsigned W = 32
) (
  input logic         clk,
  input logic         rst_n,
  input logic         shift_en,
  input logic         busy,
  input logic         done,
  input logic         start_evt,
  input logic         final_evt,
  input logic [W-1:0] x_out,
  input logic [W-1:0] y_out,
  input logic [W-1:0] z_out
);
  localparam int unsigned STEPS = W + 1;
  localparam int unsigned CW    = $clog2(STEPS + 1) + 1;

  logic [CW-1:0] pulses;

  always_ff @(posedge clk) begin
    if (!rst_n)                pulses <= '0;
    else if (start_evt)        pulses <= '0;
    else if (busy && shift_en) pulses <= pulses + 1'b1;
  end

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    final_evt |=> (done && !busy));

  assert_pulse_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pulses == CW'(STEPS)));

  assert_start_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (busy && pulses == '0));

  assert_hold_no_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !shift_en) |=> ($stable(y_out) && $stable(z_out) && busy));

  assert_x_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(x_out));
endmodule

bind shiftmd_unit shiftmd_checker #(.W(W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .shift_en  (shift_en),
  .busy      (busy),
  .done      (done),
  .start_evt (start_evt),
  .final_evt (final_evt),
  .x_out     (x_out),
  .y_out     (y_out),
  .z_out     (z_out)
);

// File: tb/shiftmd_unit_test.sv
module shiftmd_unit_test;
  localparam int unsigned N     = 4;
  localparam int unsigned W     = 8 * N;
  localparam int unsigned STEPS = W + 1;
  localparam int unsigned NV    = 13;

  // stimulus table: control byte, X, Y, Z
  localparam logic [7:0]   VC [NV] = '{8'h01, 8'h09, 8'h01, 8'h01, 8'h02, 8'h02, 8'h0A,
                                       8'h06, 8'h02, 8'h02, 8'h0C, 8'h03, 8'h01};
  localparam logic [W-1:0] VX [NV] = '{32'h00201F7C, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h0,
                                       32'h000003B4, 32'hFFFFFFFF, 32'd7, 32'd5, 32'd5,
                                       32'd0, 32'h11, 32'h22, 32'd3};
  localparam logic [W-1:0] VY [NV] = '{32'h0, 32'h12345678, 32'hFFFFFFFF, 32'h0000ABCD,
                                       32'h000001BF, 32'hFFFFFFFE, 32'd99, 32'd3, 32'd5,
                                       32'd0, 32'h5555, 32'h6666, 32'd0};
  localparam logic [W-1:0] VZ [NV] = '{32'h00723C09, 32'hFFFFFFFF, 32'hFFFFFFFF, 32'h1234,
                                       32'h00491C06, 32'hFFFFFFFF, 32'd100, 32'd77, 32'd9,
                                       32'd4, 32'h7777, 32'h8888, 32'd4};

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         shift_en = 1'b0;
  logic         wr_en = 1'b0;
  logic [1:0]   wr_sel = 2'b00;
  logic [W-1:0] wr_data = '0;
  logic [W-1:0] x_out, y_out, z_out;
  logic [7:0]   status_out;
  logic         busy, done;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  shiftmd_unit #(.N(N)) uut (.*);

  always #10 clk = ~clk;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic put(input logic [1:0] sel, input logic [W-1:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_sel = sel; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_pulses(input int gap);
    for (int p = 1; p <= int'(STEPS); p++) begin
      @(negedge clk) shift_en = 1'b1;
      @(negedge clk) shift_en = 1'b0;
      if (p == int'(STEPS) - 1) chk("R7 busy before final pulse", busy, 1);
      if (p == int'(STEPS)) begin
        chk("R7 busy after final pulse", busy, 0);
        chk("R7 done pulse", done, 1);
      end
      repeat (gap) @(negedge clk);
    end
    @(negedge clk);
    chk("R7 done lasts one cycle", done, 0);
  endtask

  task automatic finish_run();
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL R7 watchdog expired actual=hung expected=complete");
      finish_run();
    end
  end

  initial begin
    logic [W-1:0] ey, ez;
    logic [63:0]  res;
    logic         eov;
    logic [1:0]   op;

    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 x", x_out, 0);
    chk("R1 y", y_out, 0);
    chk("R1 z", z_out, 0);
    chk("R1 status", status_out, 0);
    chk("R1 busy/done", {busy, done}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < int'(NV); i++) begin
      put(2'b00, VX[i]);
      put(2'b10, VY[i]);
      put(2'b01, VZ[i]);
      put(2'b11, {{(W-8){1'b0}}, VC[i]});
      op  = VC[i][1:0];
      ey  = VC[i][3] ? '0 : VY[i];   // R5 clear Y
      ez  = VC[i][2] ? '0 : VZ[i];   // R5 clear Z
      eov = 1'b0;
      if (op == 2'b01) begin
        res = {32'd0, ey} + {32'd0, VX[i]} * {32'd0, ez};
        ey  = res[63:32];
        ez  = res[31:0];
      end else if (op == 2'b10) begin
        eov = (VX[i] <= ey);
        if (!eov) begin
          res = {ey, ez};
          ez  = W'(res / {32'd0, VX[i]});
          ey  = W'(res % {32'd0, VX[i]});
        end
      end
      chk("R4 status after control write", status_out, {7'd0, eov});
      if (op == 2'b01 || op == 2'b10) begin
        chk("R7 busy after start", busy, 1);
        run_pulses(i % 3);
      end else begin
        chk("R6 no start for code 00/11", busy, 0);
        @(negedge clk);
        chk("R6 still idle", busy, 0);
      end
      chk("R2 R3 X unchanged", x_out, VX[i]);
      if (!eov) begin
        chk(op == 2'b10 ? "R3 remainder in Y" : "R2 R5 R6 Y", y_out, ey);
        chk(op == 2'b10 ? "R3 quotient in Z" : "R2 R5 R6 Z", z_out, ez);
      end
      chk("R4 status after run", status_out, {7'd0, eov});
    end

    // R8 and R9: stalled operation with writes fired into it
    put(2'b00, 32'd6);
    put(2'b10, 32'd0);
    put(2'b01, 32'd7);
    put(2'b11, 32'h01);
    chk("R7 busy after mul start", busy, 1);
    put(2'b00, 32'd99);
    put(2'b10, 32'd1234);
    put(2'b01, 32'd5678);
    put(2'b11, 32'h0E);
    repeat (20) @(negedge clk);
    chk("R9 busy holds without pulses", busy, 1);
    chk("R8 R9 Y untouched", y_out, 0);
    chk("R8 R9 Z untouched", z_out, 7);
    chk("R8 X write ignored", x_out, 6);
    run_pulses(0);
    chk("R8 product unaffected hi", y_out, 0);
    chk("R8 product unaffected lo", z_out, 42);
    chk("R8 status not touched by ignored control", status_out, 0);

    finish_run();
  end
endmodule